// File: doc/BRIEF.md
# Configurable Serial DAC Word Receiver

This block accepts a 16-bit serial frame from a host and pulls out a 14-bit word for a digital-to-analog converter. It holds two stages of storage. The input register collects each finished frame. The DAC register holds the value that the converter actually uses.

The host controls the block with four signals: an active-low frame strobe, a serial clock, a data line and an active-low load strobe. All four are asynchronous to the system clock. The block synchronizes them and detects their falling edges in the system clock domain.

Two static pins choose one of four ways to place the payload in the frame. They select which end of the frame carries the payload and whether the first payload bit is the most or least significant bit. The load strobe then decides when the DAC register is refreshed, either on its own falling edge or automatically when the last bit of a frame arrives.

Top module: `sdac_word_rx`

## Requirements
- R1: After reset, `dac_word` is 0 and both `dac_upd` and `frame_done` are low.
- R2: A falling edge of `fsync_n` starts a frame. Each later falling edge of `sclk` that occurs while `fsync_n` is low takes one bit from `sdata`. Serial-clock edges seen while `fsync_n` is high have no effect.
- R3: Bit placement depends on the mode pins, with bits numbered 1 to 16 in arrival order:
  - {`fmt_msb_first`,`just_head`}=00: bit 3 is word bit 0 and bit 16 is word bit 13.
  - =01: bit 1 is word bit 0 and bit 14 is word bit 13.
  - =10: bit 3 is word bit 13 and bit 16 is word bit 0.
  - =11: bit 1 is word bit 13 and bit 14 is word bit 0.
- R4: The two bits of each frame that R3 does not place have no effect on the received word.
- R5: The input register is written only after all 16 bits of a frame have arrived. `frame_done` pulses for exactly one cycle at that point, and the bit count returns to zero.
- R6: When no frame is in progress, a falling edge of `load_n` copies the input register into `dac_word`.
- R7: If `load_n` is low when a frame completes, `dac_word` takes the new word in the same cycle that `frame_done` pulses. This covers both a strobe held low throughout and a strobe that fell during the frame and stayed low.
- R8: A falling edge of `load_n` during a frame causes no update at that edge. If `load_n` returns high before the frame completes, that frame causes no update at all.
- R9: A falling edge of `fsync_n` in the middle of a frame discards the bits gathered so far and restarts the count at the first bit.
- R10: `dac_word` changes only together with a `dac_upd` pulse one cycle wide, and every load raises `dac_upd`.
- R11: If `load_n` falls in the same cycle as the last bit of a frame, exactly one update occurs and it carries the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_n | input | 1 | Active-low frame strobe (asynchronous) |
| sclk | input | 1 | Serial clock; data is taken on falling edges |
| sdata | input | 1 | Serial data |
| fmt_msb_first | input | 1 | 1: first payload bit is the MSB |
| just_head | input | 1 | 1: payload occupies bits 1 to 14 of the frame |
| load_n | input | 1 | Active-low DAC register load strobe |
| dac_word | output | WORD_W | DAC register contents |
| dac_upd | output | 1 | One-cycle pulse on each DAC register load |
| frame_done | output | 1 | One-cycle pulse when a full frame has been written |

## Verification
Completing a frame and a falling edge of the load strobe can land in the same system cycle. To provoke this, the bench drives `load_n` low at the same instant as the sixteenth serial-clock fall. Both signals pass through synchronizers of equal depth, so both edges are seen in one cycle. The bench judges the result by counting `dac_upd` pulses, which must increase by exactly one, and by checking that `dac_word` equals the new frame's word rather than the earlier input register.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;

   // Placement mode as {msb_first, head_justified}
   typedef enum logic [1:0] {
      ORD_LSB_TAIL = 2'b00,
      ORD_LSB_HEAD = 2'b01,
      ORD_MSB_TAIL = 2'b10,
      ORD_MSB_HEAD = 2'b11
   } order_e;

   // Returns the word bit that frame bit idx (0-based) lands in, or -1 when discarded.
   function automatic int slot_of(input int idx, input int pad, input int word_w,
                                  input order_e ord);
      int k;
      k = (ord == ORD_LSB_HEAD || ord == ORD_MSB_HEAD) ? idx : idx - pad;
      if (k < 0 || k >= word_w) return -1;
      if (ord == ORD_MSB_TAIL || ord == ORD_MSB_HEAD) return word_w - 1 - k;
      return k;
   endfunction

endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_fall_det.sv
`timescale 1ns/1ps
module sdac_fall_det #(
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign fall[b] = prev[b] & ~lvl[b];
   end
endmodule

// File: rtl/sdac_frame_asm.sv
`timescale 1ns/1ps
module sdac_frame_asm
   import sdac_pkg::*;
#(
   parameter int WORD_W    = 14,
   parameter int FRAME_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_fall,
   input  logic              fs_lvl,
   input  logic              sck_fall,
   input  logic              sd_lvl,
   input  order_e            ord,
   output logic              busy,
   output logic              in_wr,
   output logic [WORD_W-1:0] in_next,
   output logic [WORD_W-1:0] in_word,
   output logic              frame_done
);
   localparam int PAD   = FRAME_LEN - WORD_W;
   localparam int CNT_W = $clog2(FRAME_LEN);
   localparam int IDX_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] shadow, shadow_nx;
   logic              take, last;
   int                slot;

   assign take = busy && sck_fall && !fs_lvl && !fs_fall;
   assign last = take && (cnt == LAST_IDX);

   always_comb begin
      shadow_nx = shadow;
      slot      = slot_of(int'(cnt), PAD, WORD_W, ord);
      if (take && slot >= 0) shadow_nx[IDX_W'(slot)] = sd_lvl;
   end

   assign in_wr   = last;
   assign in_next = shadow_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cnt        <= '0;
         shadow     <= '0;
         in_word    <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= last;
         if (fs_fall) begin
            busy   <= 1'b1;
            cnt    <= '0;
            shadow <= '0;
         end else if (take) begin
            shadow <= shadow_nx;
            if (last) begin
               busy    <= 1'b0;
               cnt     <= '0;
               in_word <= shadow_nx;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sdac_dac_upd.sv
`timescale 1ns/1ps
module sdac_dac_upd #(
   parameter int WORD_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_fall,
   input  logic              load_lvl,
   input  logic              busy,
   input  logic              in_wr,
   input  logic [WORD_W-1:0] in_next,
   input  logic [WORD_W-1:0] in_word,
   output logic [WORD_W-1:0] dac_word,
   output logic              dac_upd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_word <= '0;
         dac_upd  <= 1'b0;
      end else begin
         dac_upd <= 1'b0;
         if (in_wr && !load_lvl) begin
            // frame end with strobe low: take the freshly built word
            dac_word <= in_next;
            dac_upd  <= 1'b1;
         end else if (load_fall && !busy) begin
            dac_word <= in_word;
            dac_upd  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdac_word_rx.sv
`timescale 1ns/1ps
module sdac_word_rx
   import sdac_pkg::*;
#(
   parameter int WORD_W      = 14,
   parameter int FRAME_LEN   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_n,
   input  logic              sclk,
   input  logic              sdata,
   input  logic              fmt_msb_first,
   input  logic              just_head,
   input  logic              load_n,
   output logic [WORD_W-1:0] dac_word,
   output logic              dac_upd,
   output logic              frame_done
);
   if (FRAME_LEN <= WORD_W) begin : g_bad_len
      $error("FRAME_LEN must exceed WORD_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [3:0] raw_in, syn;
   logic [2:0] falls;
   logic       fs_s, sck_s, sd_s, load_s;
   logic       busy, in_wr;
   logic [WORD_W-1:0] in_next, in_word;
   order_e     ord;

   assign raw_in = {fsync_n, sclk, sdata, load_n};
   assign {fs_s, sck_s, sd_s, load_s} = syn;
   assign ord = order_e'({fmt_msb_first, just_head});

   sdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

   sdac_fall_det #(.W(3), .RST_VAL(3'b111)) u_fall (
      .clk(clk), .rst_n(rst_n), .lvl({fs_s, sck_s, load_s}), .fall(falls));

   sdac_frame_asm #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_asm (
      .clk(clk), .rst_n(rst_n), .fs_fall(falls[2]), .fs_lvl(fs_s),
      .sck_fall(falls[1]), .sd_lvl(sd_s), .ord(ord), .busy(busy),
      .in_wr(in_wr), .in_next(in_next), .in_word(in_word),
      .frame_done(frame_done));

   sdac_dac_upd #(.WORD_W(WORD_W)) u_upd (
      .clk(clk), .rst_n(rst_n), .load_fall(falls[0]), .load_lvl(load_s),
      .busy(busy), .in_wr(in_wr), .in_next(in_next), .in_word(in_word),
      .dac_word(dac_word), .dac_upd(dac_upd));
endmodule

// File: rtl/sdac_word_rx_chk.sv
`timescale 1ns/1ps
module sdac_word_rx_chk #(
   parameter int WORD_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              frame_done,
   input logic              dac_upd,
   input logic [WORD_W-1:0] dac_word,
   input logic [WORD_W-1:0] in_word,
   input logic              load_lvl
);
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !busy);

   p_auto_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !$past(load_lvl)) |-> (dac_upd && dac_word == in_word));

   p_no_mid_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_upd && !frame_done) |-> !$past(busy));

   p_change_has_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_word) |-> dac_upd);
endmodule

bind sdac_word_rx sdac_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .frame_done(frame_done),
   .dac_upd(dac_upd), .dac_word(dac_word), .in_word(in_word),
   .load_lvl(load_s));

// File: tb/sdac_word_rx_bench.sv
`timescale 1ns/1ps
module sdac_word_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync_n = 1'b1, sclk = 1'b1, sdata = 1'b0;
   logic        fmt_msb_first = 1'b0, just_head = 1'b0, load_n = 1'b1;
   logic [13:0] dac_word;
   logic        dac_upd, frame_done;

   int n_tests = 0, n_fail = 0;
   int upd_cnt = 0, done_cnt = 0, run = 0, max_run = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sdac_word_rx u_sdac_word_rx (
      .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .sclk(sclk), .sdata(sdata),
      .fmt_msb_first(fmt_msb_first), .just_head(just_head), .load_n(load_n),
      .dac_word(dac_word), .dac_upd(dac_upd), .frame_done(frame_done));

   // {frame (first bit at [15]), msb_first, head, expected word}
   localparam logic [31:0] VECS [8] = '{
      {16'hC001, 1'b0, 1'b0, 14'h2000},
      {16'hFFFE, 1'b0, 1'b0, 14'h1FFF},
      {16'h8003, 1'b0, 1'b1, 14'h0001},
      {16'h5554, 1'b0, 1'b1, 14'h2AAA},
      {16'hE5A5, 1'b1, 1'b0, 14'h25A5},
      {16'h3FFF, 1'b1, 1'b0, 14'h3FFF},
      {16'hABCF, 1'b1, 1'b1, 14'h2AF3},
      {16'h0003, 1'b1, 1'b1, 14'h0000}
   };

   always @(negedge clk) begin
      if (rst_n) begin
         if (dac_upd) begin upd_cnt++; run++; end else run = 0;
         if (run > max_run) max_run = run;
         if (frame_done) done_cnt++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Sends nbits of f; load strobe actions at bit indices (-1 = none)
   task automatic send(input logic [15:0] f, input int nbits, input int drop_at,
                       input int rise_at, input bit drop_on_last, input bit end_fs);
      @(negedge clk);
      fsync_n = 1'b0;
      wait_cyc(4);
      for (int i = 0; i < nbits; i++) begin
         if (i == drop_at) load_n = 1'b0;
         if (i == rise_at) load_n = 1'b1;
         sdata = f[15-i];
         wait_cyc(8);
         sclk = 1'b0;
         if (drop_on_last && i == nbits - 1) load_n = 1'b0;
         wait_cyc(8);
         sclk = 1'b1;
      end
      wait_cyc(4);
      if (end_fs) fsync_n = 1'b1;
      wait_cyc(8);
   endtask

   initial begin
      int u0, d0;
      logic [13:0] prev;
      wait_cyc(10);
      rst_n = 1'b1;
      wait_cyc(1);
      chk("R1 dac_word", dac_word, 0);
      chk("R1 dac_upd", dac_upd, 0);
      chk("R1 frame_done", frame_done, 0);

      // table: load held low, automatic update at frame end
      load_n = 1'b0;
      wait_cyc(8);
      for (int v = 0; v < 8; v++) begin
         fmt_msb_first = VECS[v][15];
         just_head     = VECS[v][14];
         u0 = upd_cnt; d0 = done_cnt;
         send(VECS[v][31:16], 16, -1, -1, 1'b0, 1'b1);
         chk("R3/R4 word", dac_word, VECS[v][13:0]);
         chk("R7 auto update count", upd_cnt - u0, 1);
         chk("R5 frame_done count", done_cnt - d0, 1);
      end

      // R6: strobe high during frame, then a strobe fall loads
      load_n = 1'b1; fmt_msb_first = 1'b1; just_head = 1'b1;
      wait_cyc(8);
      prev = dac_word; u0 = upd_cnt;
      send(16'h1234, 16, -1, -1, 1'b0, 1'b1);
      chk("R6 no load before strobe", dac_word, prev);
      chk("R6 no pulse before strobe", upd_cnt - u0, 0);
      load_n = 1'b0;
      wait_cyc(8);
      chk("R6 strobe load", dac_word, 14'h048D);
      chk("R6 pulse", upd_cnt - u0, 1);
      load_n = 1'b1;
      wait_cyc(8);

      // R8/R7: strobe falls mid-frame and stays low
      fmt_msb_first = 1'b1; just_head = 1'b0;
      u0 = upd_cnt;
      send(16'h0ABC, 16, 5, -1, 1'b0, 1'b1);
      chk("R8 single update at end", upd_cnt - u0, 1);
      chk("R7 word after mid fall", dac_word, 14'h0ABC);
      load_n = 1'b1;
      wait_cyc(8);

      // R8: strobe falls and rises inside the frame
      u0 = upd_cnt;
      send(16'h1111, 16, 3, 10, 1'b0, 1'b1);
      chk("R8 no update", upd_cnt - u0, 0);
      chk("R8 dac held", dac_word, 14'h0ABC);
      load_n = 1'b0;
      wait_cyc(8);
      chk("R6 later strobe loads", dac_word, 14'h1111);

      // R9: abort after 7 bits, then a full frame (strobe held low)
      d0 = done_cnt; u0 = upd_cnt;
      send(16'hFFFF, 7, -1, -1, 1'b0, 1'b1);
      chk("R5 partial frame no write", done_cnt - d0, 0);
      chk("R5 partial frame no update", dac_word, 14'h1111);
      send(16'h2222, 16, -1, -1, 1'b0, 1'b1);
      chk("R9 restart word", dac_word, 14'h2222);
      chk("R9 one frame_done", done_cnt - d0, 1);
      chk("R9 one update", upd_cnt - u0, 1);

      // R2: serial clock with frame strobe high is ignored
      d0 = done_cnt;
      for (int i = 0; i < 16; i++) begin
         wait_cyc(8); sclk = 1'b0; wait_cyc(8); sclk = 1'b1;
      end
      wait_cyc(8);
      chk("R2 idle edges ignored", done_cnt - d0, 0);
      chk("R2 dac unchanged", dac_word, 14'h2222);

      // R11: strobe falls with the last serial edge
      load_n = 1'b1;
      wait_cyc(8);
      u0 = upd_cnt;
      send(16'h1357, 16, -1, -1, 1'b1, 1'b1);
      chk("R11 one update", upd_cnt - u0, 1);
      chk("R11 new word", dac_word, 14'h1357);

      chk("R10 pulse width", max_run, 1);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule